// File: doc/BRIEF.md
# Serially Loaded Program-Bank Mapper

This block is a cartridge memory mapper on an 8-bit CPU bus. Software cannot write its bank registers in parallel. Instead, each CPU write anywhere in the upper half of the address space delivers a single data bit, taken from data bit 0, into a five-bit shift path. The fifth such write commits the collected value. The register that receives it is chosen by the address of that fifth write. A write with data bit 7 set aborts any partial load. The same write also forces the program banking mode back to the power-on mode.

From the committed control and program-bank values, the block produces the ROM address bits above A13 for CPU reads in `$8000`–`$FFFF`. Each read falls in one of two 16 KiB windows. The mode decides whether the two windows switch together as one 32 KiB unit, or whether one window is pinned to the first or last bank while the other follows the bank register. The two character-bank registers are only stored.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset the mode is 3 and the program bank is 0, so reads at `$8000` map to bank 0 and reads at `$C000` map to bank 15.
- R2: A write counts as a load write when `cpu_addr[15]`=1 and `cpu_data[7]`=0. Only `cpu_data[0]` is shifted in, least significant bit first. The fifth load write commits the five bits to the register selected by its own `cpu_addr[14:13]`: 0 control, 1 and 2 character banks, 3 program bank. Program bank bits [3:0] form the bank number. Control bits [3:2] form the mode.
- R3: The first four load writes of a sequence leave the bank outputs unchanged.
- R4: A write with `cpu_addr[15]`=1 and `cpu_data[7]`=1 empties the shift path, so the next five load writes form a fresh value.
- R5: That reset write also sets the mode to 3 and keeps the program bank.
- R6: Writes with `cpu_addr[15]`=0 are ignored and do not advance the shift path.
- R7: Modes 0 and 1 select a 32 KiB unit, with output `{bank[3:1], cpu_addr[14]}`.
- R8: In mode 2, `$8000`–`$BFFF` maps to bank 0 and `$C000`–`$FFFF` maps to the bank register.
- R9: In mode 3, `$8000`–`$BFFF` maps to the bank register and `$C000`–`$FFFF` maps to bank 15.
- R10: Commits to the character-bank registers do not change the program mapping.
- R11: With `cpu_addr[15]`=0 the bank output is 0.
- R12: After a commit the shift path is empty, so a following load is independent of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used both for writes and for mapping reads |
| cpu_data | input | 8 | CPU write data |
| prg_bank_a | output | 4 | Program-ROM address bits 17:14 for the current address |

## Verification
The hardest situation to reach is a load that is broken partway: some bits are already shifted in when a reset write or an ignored low-address write arrives. The stimulus builds these cases directly. In one, three load bits are followed by a reset write and then a full fresh load. In another, writes below `$8000` are interleaved inside a load, so that a mistaken shift would commit early with a different value. A further sequence sends its first four writes to the control address and its fifth to the program-bank address, which shows that only the final address picks the target.

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper #(
  parameter int BANK_W    = 4,
  parameter int SHIFT_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  output logic [BANK_W-1:0] prg_bank_a
);
  localparam int CNT_W = $clog2(SHIFT_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_LEN - 1);
  localparam logic [SHIFT_LEN-1:0] CTRL_INIT = SHIFT_LEN'(5'b01100);

  logic [SHIFT_LEN-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]     cnt_q;
  logic [SHIFT_LEN-1:0] ctrl_q, chr0_q, chr1_q, prg_q;
  logic                 wr_hit, rst_hit, load_hit, last_bit;
  logic [1:0]           mode;
  logic [BANK_W-1:0]    bank;

  assign wr_hit   = cpu_wr & cpu_addr[15];
  assign rst_hit  = wr_hit & cpu_data[7];
  assign load_hit = wr_hit & ~cpu_data[7];
  assign last_bit = (cnt_q == LAST);
  assign shift_d  = {cpu_data[0], shift_q[SHIFT_LEN-1:1]};
  assign mode     = ctrl_q[3:2];
  assign bank     = prg_q[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      ctrl_q  <= CTRL_INIT;
      chr0_q  <= '0;
      chr1_q  <= '0;
      prg_q   <= '0;
    end else if (rst_hit) begin
      shift_q     <= '0;
      cnt_q       <= '0;
      ctrl_q[3:2] <= 2'b11;
    end else if (load_hit) begin
      if (last_bit) begin
        shift_q <= '0;
        cnt_q   <= '0;
        case (cpu_addr[14:13])
          2'd0: ctrl_q <= shift_d;
          2'd1: chr0_q <= shift_d;
          2'd2: chr1_q <= shift_d;
          default: prg_q <= shift_d;
        endcase
      end else begin
        shift_q <= shift_d;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!cpu_addr[15]) begin
      prg_bank_a = '0;
    end else begin
      case (mode)
        2'd2:    prg_bank_a = cpu_addr[14] ? bank : '0;
        2'd3:    prg_bank_a = cpu_addr[14] ? '1 : bank;
        default: prg_bank_a = {bank[BANK_W-1:1], cpu_addr[14]};
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{chr0_q, chr1_q, prg_q, ctrl_q, cpu_data[6:1], cpu_addr[12:0]};
endmodule

module serial_bank_mapper_chk #(
  parameter int BANK_W    = 4,
  parameter int SHIFT_LEN = 5,
  parameter int CNT_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_wr,
  input logic [15:0]          cpu_addr,
  input logic [7:0]           cpu_data,
  input logic [BANK_W-1:0]    prg_bank_a,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [SHIFT_LEN-1:0] ctrl_q,
  input logic [SHIFT_LEN-1:0] prg_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_LEN - 1);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_partial_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && !cpu_data[7] && cnt_q != LAST)
      |=> ($stable(prg_q) && $stable(ctrl_q)));

  assert_reset_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_data[7]) |=> (cnt_q == '0));

  assert_reset_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_data[7]) |=> (ctrl_q[3:2] == 2'b11 && $stable(prg_q)));

  assert_ignore_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15]) |=> $stable(cnt_q));

  assert_fixed_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3:2] == 2'b11 && cpu_addr[15:14] == 2'b11) |-> (&prg_bank_a));

  assert_low_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (prg_bank_a == '0));
endmodule

bind serial_bank_mapper serial_bank_mapper_chk #(
  .BANK_W(BANK_W), .SHIFT_LEN(SHIFT_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_data(cpu_data), .prg_bank_a(prg_bank_a), .cnt_q(cnt_q),
  .ctrl_q(ctrl_q), .prg_q(prg_q)
);

// File: tb/tb_serial_bank_mapper.sv
`timescale 1ns/1ps
module tb_serial_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic [3:0]  prg_bank_a;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .prg_bank_a(prg_bank_a)
  );

  task automatic wr1(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_data = 8'h00;
  endtask

  task automatic load(input logic [15:0] a, input logic [4:0] v);
    for (int i = 0; i < 5; i++) wr1(a, {7'b0111111, v[i]});
  endtask

  task automatic rd(input logic [15:0] a, input logic [3:0] exp, input string tag);
    cpu_addr = a;
    #0.5;
    checks++;
    if (prg_bank_a !== exp) begin
      errors++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, prg_bank_a, exp);
    end
  endtask

  task automatic t_reset;
    rd(16'h8000, 4'h0, "R1 low window");
    rd(16'hC123, 4'hF, "R1 high window");
    rd(16'h4000, 4'h0, "R11 below 8000");
  endtask

  task automatic t_basic;
    load(16'hE000, 5'h05);
    rd(16'h8000, 4'h5, "R2 commit R9 low");
    rd(16'hFFFF, 4'hF, "R9 high");
    load(16'hE000, 5'h1A);
    rd(16'h9000, 4'hA, "R12 second load");
  endtask

  task automatic t_partial;
    for (int i = 0; i < 4; i++) wr1(16'h8000, {7'd0, 1'(4'h9 >> i)});
    rd(16'h8000, 4'hA, "R3 partial load");
    wr1(16'hE000, 8'h00);
    rd(16'h8000, 4'h9, "R2 fifth address picks target");
    rd(16'hC000, 4'hF, "R2 control untouched");
  endtask

  task automatic t_abort;
    for (int i = 0; i < 3; i++) wr1(16'hE000, 8'h01);
    wr1(16'hA000, 8'h80);
    load(16'hE000, 5'h06);
    rd(16'h8000, 4'h6, "R4 fresh load after reset write");
    load(16'h8000, 5'h08);
    rd(16'h8000, 4'h0, "R8 low fixed 0");
    rd(16'hC000, 4'h6, "R8 high switchable");
    wr1(16'hFFFF, 8'hFF);
    rd(16'h8000, 4'h6, "R5 mode 3 after reset write");
    rd(16'hC000, 4'hF, "R5 high fixed last");
  endtask

  task automatic t_mode32;
    load(16'hE000, 5'h0B);
    load(16'h8000, 5'h00);
    rd(16'h8000, 4'hA, "R7 mode0 low");
    rd(16'hC000, 4'hB, "R7 mode0 high");
    load(16'h9FFF, 5'h04);
    rd(16'hBFFF, 4'hA, "R7 mode1 low");
    rd(16'hE000, 4'hB, "R7 mode1 high");
    load(16'h8000, 5'h0C);
  endtask

  task automatic t_ignore_low;
    wr1(16'hE000, 8'h01);
    wr1(16'hE000, 8'h00);
    for (int i = 0; i < 3; i++) wr1(16'h6000, 8'h01);
    wr1(16'hE000, 8'h00);
    wr1(16'hE000, 8'h01);
    rd(16'h8000, 4'hB, "R6 no early commit");
    wr1(16'hE000, 8'h01);
    rd(16'h8000, 4'h9, "R6 low writes not shifted");
  endtask

  task automatic t_chr;
    load(16'hA000, 5'h1F);
    load(16'hC000, 5'h13);
    rd(16'h8000, 4'h9, "R10 chr commits keep low");
    rd(16'hC000, 4'hF, "R10 chr commits keep high");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_partial;
    t_abort;
    t_mode32;
    t_ignore_low;
    t_chr;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule